// File: doc/BRIEF.md
# Masked GPIO Port Register Bank

This block is the register side of one fast general-purpose I/O port. It holds a direction register, an output latch and a per-pin mask. Software reaches them through a small memory-mapped bus that supports byte, half-word and word writes. The output latch can be changed in three ways: a set register forces bits high, a clear register forces bits low, and a pin-value register loads the latch directly. Each of these paths changes only the pins whose mask bit is 0.

The mask also gates reads. A read of the pin-value register returns the synchronized pad input for unmasked pins and 0 for masked pins. The pads themselves are outside the block. They appear as an output vector, an output-enable vector taken from the direction register, and a raw input vector that passes through a two-flop synchronizer inside the block.

Each register sits at a word address. The byte strobes select which 8-bit lanes of that word a write touches. This lets the mask be written as four independent bytes or as two half-words, all sharing the one 32-bit mask storage.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the mask, direction and output latch are all zero, so pin_out and pin_oe read 0.
- R2: A write to the set register (word address 3, byte address 0x0C) drives 1 on every unmasked pin in a strobed lane whose write-data bit is 1. Data bits of 0 leave their pins unchanged.
- R3: A write to the clear register (byte address 0x10) drives 0 on every unmasked pin in a strobed lane whose write-data bit is 1. Data bits of 0 leave their pins unchanged.
- R4: A write to the pin-value register (byte address 0x08) loads the write data into the output latch for unmasked pins in strobed lanes.
- R5: A pin whose mask bit is 1 keeps its output value through any write to the set, clear or pin-value register.
- R6: A read of the pin-value register returns the synchronized input for pins whose mask bit is 0, and returns 0 for pins whose mask bit is 1.
- R7: The mask (byte address 0x04) can be written one byte at a time. Strobe bit k alone updates mask bits 8k to 8k+7, with the lowest pin in byte bit 0, and leaves every other mask bit unchanged.
- R8: Strobes 0 and 1 together write mask bits 0–15 as a lower half-word. Strobes 2 and 3 together write mask bits 16–31 as an upper half-word. Every byte, half-word and word view reads back from the same storage.
- R9: On any register, only the strobed byte lanes change. A write with no strobes changes nothing, and neither does a write to the set or clear register with all-zero data.
- R10: The direction register (byte address 0x00, 1 = output) drives pin_oe directly and is not affected by the mask.
- R11: A change on pin_in shows up in the pin-value read only after two rising clock edges. After one edge the read still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin (from direction register) |

## Verification
The hardest situation to reach is a write whose mask, strobe lanes and data bits disagree on the same cycle. The outcome only differs from plain behaviour where a strobed lane carries both masked and unmasked pins with data bits of both values. To reach it, random writes draw mask patterns, strobe combinations and data independently, and directed cases place a half-masked byte under a set, a clear and a pin write. The synchronizer delay is probed by reading the pin-value register one edge and then two edges after the input changes.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   // Word index of each register (byte address / 4)
   localparam int unsigned IDX_DIR  = 0;
   localparam int unsigned IDX_MASK = 1;
   localparam int unsigned IDX_PIN  = 2;
   localparam int unsigned IDX_SET  = 3;
   localparam int unsigned IDX_CLR  = 4;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_DIR  = 3'd1,
      SEL_MASK = 3'd2,
      SEL_PIN  = 3'd3,
      SEL_SET  = 3'd4,
      SEL_CLR  = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_LOAD = 2'd3
   } out_op_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad
      $error("gpio_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] flop_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flop_q <= '0;
         else        flop_q <= d;
      end
      assign q = flop_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/gpio_lane_reg.sv
module gpio_lane_reg #(
   parameter int unsigned W         = 32,
   parameter logic [W-1:0] RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] lane_bits,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= (q & ~lane_bits) | (wdata & lane_bits);
   end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
   import gpio_mask_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  out_op_e      op,
   input  logic [W-1:0] lane_bits,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   logic [W-1:0] open_bits;
   logic [W-1:0] nxt;

   assign open_bits = lane_bits & ~mask;

   always_comb begin
      unique case (op)
         OP_SET:  nxt = q | (wdata & open_bits);
         OP_CLR:  nxt = q & ~(wdata & open_bits);
         OP_LOAD: nxt = (q & ~open_bits) | (wdata & open_bits);
         default: nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int unsigned PIN_W       = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [PIN_W-1:0]     bus_wdata,
   input  logic [PIN_W/8-1:0]   bus_strb,
   input  logic                 bus_we,
   output logic [PIN_W-1:0]     bus_rdata,
   input  logic [PIN_W-1:0]     pin_in,
   output logic [PIN_W-1:0]     pin_out,
   output logic [PIN_W-1:0]     pin_oe
);

   localparam int unsigned LANES  = PIN_W / 8;
   localparam int unsigned IDX_W  = ADDR_W - 2;

   if (PIN_W % 16 != 0 || PIN_W == 0) begin : g_bad_width
      $error("gpio_mask_port: PIN_W must be a non-zero multiple of 16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_mask_port: ADDR_W must cover five registers");
   end

   // Address decode (word index; low two bits ignored, lanes come from strobes)
   logic [IDX_W-1:0] word_idx;
   reg_sel_e         sel;

   assign word_idx = bus_addr[ADDR_W-1:2];

   always_comb begin
      if      (word_idx == IDX_W'(IDX_DIR))  sel = SEL_DIR;
      else if (word_idx == IDX_W'(IDX_MASK)) sel = SEL_MASK;
      else if (word_idx == IDX_W'(IDX_PIN))  sel = SEL_PIN;
      else if (word_idx == IDX_W'(IDX_SET))  sel = SEL_SET;
      else if (word_idx == IDX_W'(IDX_CLR))  sel = SEL_CLR;
      else                                   sel = SEL_NONE;
   end

   // Strobe expansion to per-bit lane enables
   logic [PIN_W-1:0] lane_bits;
   for (genvar b = 0; b < PIN_W; b++) begin : g_lane
      assign lane_bits[b] = bus_strb[b / 8];
   end

   logic wr_dir, wr_mask;
   assign wr_dir  = bus_we && (sel == SEL_DIR);
   assign wr_mask = bus_we && (sel == SEL_MASK);

   out_op_e op;
   always_comb begin
      op = OP_HOLD;
      if (bus_we) begin
         unique case (sel)
            SEL_SET: op = OP_SET;
            SEL_CLR: op = OP_CLR;
            SEL_PIN: op = OP_LOAD;
            default: op = OP_HOLD;
         endcase
      end
   end

   // Storage
   logic [PIN_W-1:0] mask_q;
   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] in_sync;

   gpio_lane_reg #(.W(PIN_W), .RST_VAL('0)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_dir),
      .lane_bits (lane_bits),
      .wdata     (bus_wdata),
      .q         (dir_q)
   );

   gpio_lane_reg #(.W(PIN_W), .RST_VAL('0)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_mask),
      .lane_bits (lane_bits),
      .wdata     (bus_wdata),
      .q         (mask_q)
   );

   gpio_out_latch #(.W(PIN_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .lane_bits (lane_bits),
      .mask      (mask_q),
      .wdata     (bus_wdata),
      .q         (pin_out)
   );

   gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_sync)
   );

   assign pin_oe = dir_q;

   // Read mux
   always_comb begin
      unique case (sel)
         SEL_DIR:  bus_rdata = dir_q;
         SEL_MASK: bus_rdata = mask_q;
         SEL_PIN:  bus_rdata = in_sync & ~mask_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
   import gpio_mask_pkg::*;
#(
   parameter int unsigned PIN_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_we,
   input logic [PIN_W/8-1:0] bus_strb,
   input logic [PIN_W-1:0]   bus_rdata,
   input logic [PIN_W-1:0]   pin_out,
   input logic [PIN_W-1:0]   pin_oe,
   input logic [PIN_W-1:0]   mask_q,
   input reg_sel_e           sel
);

   logic out_wr;
   assign out_wr = bus_we && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_PIN);

   assert_masked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |=> ((pin_out & $past(mask_q)) == ($past(pin_out) & $past(mask_q))));

   assert_read_masked_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_PIN) |-> ((bus_rdata & mask_q) == '0));

   assert_out_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_wr |=> $stable(pin_out));

   assert_oe_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && sel == SEL_DIR) |=> $stable(pin_oe));

   assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && sel == SEL_MASK) |=> $stable(mask_q));

   assert_mask_lane0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_MASK && !bus_strb[0]) |=> (mask_q[7:0] == $past(mask_q[7:0])));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PIN_W(PIN_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_strb  (bus_strb),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .mask_q    (mask_q),
   .sel       (sel)
);

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;

   localparam logic [4:0] A_DIR  = 5'h00;
   localparam logic [4:0] A_MASK = 5'h04;
   localparam logic [4:0] A_PIN  = 5'h08;
   localparam logic [4:0] A_SET  = 5'h0C;
   localparam logic [4:0] A_CLR  = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_strb = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] m_out, m_dir, m_mask;

   always #10 clk = ~clk;   // 50 MHz

   gpio_mask_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_strb  (bus_strb),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   function automatic logic [31:0] lanes(input logic [3:0] s);
      logic [31:0] r;
      for (int b = 0; b < 32; b++) r[b] = s[b/8];
      return r;
   endfunction

   function automatic void model_write(input logic [4:0] a, input logic [31:0] d,
                                       input logic [3:0] s);
      logic [31:0] ln, op;
      ln = lanes(s);
      op = ln & ~m_mask;
      case (a[4:2])
         3'd0: m_dir  = (m_dir & ~ln) | (d & ln);
         3'd1: m_mask = (m_mask & ~ln) | (d & ln);
         3'd2: m_out  = (m_out & ~op) | (d & op);
         3'd3: m_out  = m_out | (d & op);
         3'd4: m_out  = m_out & ~(d & op);
         default: ;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_strb = s; bus_we = 1'b1;
      @(posedge clk);
      model_write(a, d, s);
      @(negedge clk);
      bus_we = 1'b0; bus_strb = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic check_state(input string req);
      logic [31:0] v;
      #1;
      check(req, pin_out, m_out);
      check(req, pin_oe, m_dir);
      rd(A_MASK, v);
      check(req, v, m_mask);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      m_out = '0; m_dir = '0; m_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_state("R1");

      // R2 set with zero mask, zero data bits ignored
      wr(A_SET, 32'hF0F0_00FF, 4'hF);
      check_state("R2");
      check("R2", pin_out, 32'hF0F0_00FF);
      // R3 clear
      wr(A_CLR, 32'h3000_000F, 4'hF);
      check("R3", pin_out, 32'hC0F0_00F0);
      // R4 pin-value load
      wr(A_PIN, 32'h1234_5678, 4'hF);
      check("R4", pin_out, 32'h1234_5678);

      // R7 byte lane 2 of mask
      wr(A_MASK, 32'hAAAA_AAAA, 4'b0100);
      rd(A_MASK, v);
      check("R7", v, 32'h00AA_0000);
      // R8 upper half-word, then lower half-word
      wr(A_MASK, 32'h0F0F_0000, 4'b1100);
      rd(A_MASK, v);
      check("R8", v, 32'h0F0F_0000);
      wr(A_MASK, 32'hFFFF_00F0, 4'b0011);
      rd(A_MASK, v);
      check("R8", v, 32'h0F0F_00F0);

      // R5 masked pins hold across set, clear, load in half-masked bytes
      wr(A_SET, 32'hFFFF_FFFF, 4'hF);
      check("R5", pin_out, 32'hF0F0_FF0F | (32'h1234_5678 & 32'h0F0F_00F0));
      wr(A_CLR, 32'hFFFF_FFFF, 4'hF);
      check("R5", pin_out, 32'h1234_5678 & 32'h0F0F_00F0);
      wr(A_PIN, 32'hA5A5_A5A5, 4'hF);
      check("R5", pin_out, m_out);

      // R9 no strobes / zero data change nothing
      wr(A_PIN, 32'hFFFF_FFFF, 4'h0);
      check("R9", pin_out, m_out);
      wr(A_SET, 32'h0, 4'hF);
      check("R9", pin_out, m_out);
      wr(A_PIN, 32'h0000_0000, 4'b0010);
      check_state("R9");

      // R10 direction ignores mask
      wr(A_MASK, 32'hFFFF_FFFF, 4'hF);
      wr(A_DIR, 32'h8001_7FFE, 4'hF);
      check("R10", pin_oe, 32'h8001_7FFE);
      rd(A_DIR, v);
      check("R10", v, 32'h8001_7FFE);

      // R6 read gating
      wr(A_MASK, 32'h0000_FFFF, 4'hF);
      @(negedge clk); pin_in = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      rd(A_PIN, v);
      check("R6", v, 32'hDEAD_0000);

      // R11 synchronizer delay
      @(negedge clk);
      pin_in = 32'h1357_9BDF;
      bus_addr = A_PIN;
      @(posedge clk); #2;
      check("R11", bus_rdata, 32'hDEAD_0000);
      @(posedge clk); #2;
      check("R11", bus_rdata, 32'h1357_0000);

      // Random mix (R2..R9)
      for (int i = 0; i < 400; i++) begin
         logic [4:0]  a;
         logic [31:0] d;
         logic [3:0]  s;
         case ($urandom_range(0, 4))
            0: a = A_DIR; 1: a = A_MASK; 2: a = A_PIN; 3: a = A_SET; default: a = A_CLR;
         endcase
         d = $urandom();
         case ($urandom_range(0, 5))
            0: s = 4'hF; 1: s = 4'h3; 2: s = 4'hC; 3: s = 4'h0;
            default: s = 4'(1 << $urandom_range(0, 3));
         endcase
         wr(a, d, s);
         if (i % 20 == 0) begin
            @(negedge clk); pin_in = $urandom();
            repeat (2) @(negedge clk);
            rd(A_PIN, v);
            check("R6", v, pin_in & ~m_mask);
         end
         #1;
         check("R5", pin_out, m_out);
         if (i % 10 == 0) check_state("R9");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule